// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. It takes two 32-bit register operands and a 3-bit function code. It runs them through a single subtractor that computes a − b, and derives four flags from that one result: zero, borrow, signed overflow and sign. Every branch comparison is a small function of those flags. Equality and inequality come from the zero flag. Unsigned order comes from the borrow. Signed order comes from sign XOR overflow, not from the sign bit alone, because the subtraction can overflow.

The difference and the raw flags are also driven out, for debug and for greater-than decisions. A parameter adds an output register with an active-low asynchronous reset. A second parameter computes equality with a bitwise XOR reduction, which avoids the carry chain, instead of using the subtractor's zero flag. Target address arithmetic and anything to do with the program counter stay outside the block.

Top module: `brc_unit`

## Requirements
- R1: With function code 3'b000, taken_o is 1 exactly when a_i equals b_i.
- R2: With function code 3'b001, taken_o is 1 exactly when a_i differs from b_i.
- R3: With function code 3'b110, taken_o is 1 exactly when a_i < b_i as unsigned numbers. borrow_o equals that same unsigned less-than for every function code.
- R4: With function code 3'b111, taken_o is 1 exactly when a_i >= b_i as unsigned numbers.
- R5: ovf_o is 1 exactly when a_i − b_i overflows as a two's-complement subtraction, that is, when the carry into bit 31 differs from the carry out of bit 31. For example, 0x80000000 − 0x7FFFFFFF overflows.
- R6: With function code 3'b100, taken_o is 1 exactly when a_i < b_i as signed numbers. This includes operand pairs whose difference has a clear sign bit, such as 0x80000000 versus 0x7FFFFFFF, which is taken.
- R7: With function code 3'b101, taken_o is 1 exactly when a_i >= b_i as signed numbers.
- R8: Function codes 3'b010 and 3'b011 never give taken_o = 1.
- R9: diff_o is (a_i − b_i) mod 2^32, zero_o is 1 when diff_o is zero, and sign_o is bit 31 of diff_o.
- R10: gt_s_o is 1 exactly when a_i > b_i signed. gt_u_o is 1 exactly when a_i > b_i unsigned.
- R11: With REG_OUT = 1 (the default), every output shows the result for the inputs present at the previous rising clock edge. While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset of the output register |
| a_i | input | 32 | First operand (minuend) |
| b_i | input | 32 | Second operand (subtrahend) |
| func_i | input | 3 | Branch function code |
| taken_o | output | 1 | Branch decision |
| zero_o | output | 1 | Difference is zero |
| borrow_o | output | 1 | Unsigned borrow of a − b |
| ovf_o | output | 1 | Signed overflow of a − b |
| sign_o | output | 1 | Most significant bit of the difference |
| gt_s_o | output | 1 | Signed greater-than |
| gt_u_o | output | 1 | Unsigned greater-than |
| diff_o | output | 32 | Difference a − b |

## Verification
The embedded checks run on every evaluation and compare the decisions against separate logic:
- the borrow against a behavioural unsigned compare;
- sign XOR overflow against bit 32 of a 33-bit sign-extended difference;
- the XOR-reduction equality against the subtractor's zero flag;
- the reserved function codes against the decision output.

On the registered outputs, a clocked check holds a zero difference free of borrow, overflow and greater-than. Only the bench's scenarios can show the following:
- the one-cycle output latency and the cleared state under reset;
- that each function code selects the right relation;
- that the corner pairs built from 0, 1, −1, the most negative and the most positive value resolve correctly under both signed and unsigned order.

// File: rtl/brc_pkg.sv
package brc_pkg;
  // function code values follow the branch encoding decoded upstream
  typedef enum logic [2:0] {
    FN_EQ  = 3'b000,
    FN_NE  = 3'b001,
    FN_LT  = 3'b100,
    FN_GE  = 3'b101,
    FN_LTU = 3'b110,
    FN_GEU = 3'b111
  } br_fn_e;

  typedef struct packed {
    logic zero;
    logic borrow;
    logic ovf;
    logic sign;
  } sub_flags_t;
endpackage

// File: rtl/brc_sub.sv
module brc_sub
  import brc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] diff_o,
  output sub_flags_t       flags_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] nb;
  logic [WIDTH-1:0] low;
  logic             c_msb_in;
  logic             c_msb_out;
  logic             msb_sum;

  assign nb = ~b_i;
  // a + ~b + 1 split at the msb so the carry into it is visible
  assign low       = {1'b0, a_i[MSB-1:0]} + {1'b0, nb[MSB-1:0]} + WIDTH'(1);
  assign c_msb_in  = low[MSB];
  assign msb_sum   = a_i[MSB] ^ nb[MSB] ^ c_msb_in;
  assign c_msb_out = (a_i[MSB] & nb[MSB]) | (a_i[MSB] & c_msb_in) | (nb[MSB] & c_msb_in);

  assign diff_o         = {msb_sum, low[MSB-1:0]};
  assign flags_o.zero   = ~|diff_o;
  assign flags_o.borrow = ~c_msb_out;
  assign flags_o.ovf    = c_msb_in ^ c_msb_out;
  assign flags_o.sign   = msb_sum;

  logic [WIDTH:0] wide_diff;
  assign wide_diff = {a_i[MSB], a_i} - {b_i[MSB], b_i};

  always_comb begin
    // R3
    borrow_chk: assert (flags_o.borrow == (a_i < b_i));
    // R6
    slt_wide_chk: assert (wide_diff[WIDTH] == (flags_o.sign ^ flags_o.ovf));
  end
endmodule

// File: rtl/brc_decide.sv
module brc_decide
  import brc_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter bit EQ_XOR = 1'b1
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [2:0]       func_i,
  input  sub_flags_t       flags_i,
  output logic             taken_o,
  output logic             gt_s_o,
  output logic             gt_u_o
);
  logic eq;
  logic lt_s;
  logic lt_u;

  generate
    if (EQ_XOR) begin : g_eq_xor
      assign eq = ~|(a_i ^ b_i);
    end else begin : g_eq_sub
      assign eq = flags_i.zero;
    end
  endgenerate

  assign lt_s   = flags_i.sign ^ flags_i.ovf;
  assign lt_u   = flags_i.borrow;
  assign gt_s_o = ~flags_i.zero & ~lt_s;
  assign gt_u_o = ~flags_i.zero & ~lt_u;

  always_comb begin
    unique case (func_i)
      FN_EQ:   taken_o = eq;
      FN_NE:   taken_o = ~eq;
      FN_LT:   taken_o = lt_s;
      FN_GE:   taken_o = ~lt_s;
      FN_LTU:  taken_o = lt_u;
      FN_GEU:  taken_o = ~lt_u;
      default: taken_o = 1'b0;
    endcase
  end

  always_comb begin
    // R1
    eq_src_chk: assert (eq == flags_i.zero);
    // R8
    rsvd_fn_chk: assert (!(func_i[2:1] == 2'b01 && taken_o));
  end
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1,
  parameter bit EQ_XOR  = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] a_i,
  input  logic [31:0] b_i,
  input  logic [2:0]  func_i,
  output logic        taken_o,
  output logic        zero_o,
  output logic        borrow_o,
  output logic        ovf_o,
  output logic        sign_o,
  output logic        gt_s_o,
  output logic        gt_u_o,
  output logic [31:0] diff_o
);
  localparam int RES_W = WIDTH + 7;

  logic [WIDTH-1:0] diff_c;
  sub_flags_t       flags_c;
  logic             taken_c;
  logic             gt_s_c;
  logic             gt_u_c;
  logic [RES_W-1:0] res_c;
  logic [RES_W-1:0] res_q;

  brc_sub #(.WIDTH(WIDTH)) i_sub (
    .a_i    (a_i),
    .b_i    (b_i),
    .diff_o (diff_c),
    .flags_o(flags_c)
  );

  brc_decide #(.WIDTH(WIDTH), .EQ_XOR(EQ_XOR)) i_decide (
    .a_i    (a_i),
    .b_i    (b_i),
    .func_i (func_i),
    .flags_i(flags_c),
    .taken_o(taken_c),
    .gt_s_o (gt_s_c),
    .gt_u_o (gt_u_c)
  );

  assign res_c = {taken_c, flags_c.zero, flags_c.borrow, flags_c.ovf,
                  flags_c.sign, gt_s_c, gt_u_c, diff_c};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) res_q <= '0;
        else         res_q <= res_c;
      end

      // R10
      zero_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_o |-> (!borrow_o && !ovf_o && !gt_s_o && !gt_u_o));
    end else begin : g_comb
      assign res_q = res_c;
    end
  endgenerate

  assign {taken_o, zero_o, borrow_o, ovf_o, sign_o, gt_s_o, gt_u_o, diff_o} = res_q;
endmodule

// File: tb/test_brc_unit.sv
`timescale 1ns/1ps
module test_brc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [2:0]  fn = '0;
  logic        taken, zero, borrow, ovf, sign, gt_s, gt_u;
  logic [31:0] diff;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  brc_unit i_brc_unit (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .func_i(fn),
    .taken_o(taken), .zero_o(zero), .borrow_o(borrow), .ovf_o(ovf),
    .sign_o(sign), .gt_s_o(gt_s), .gt_u_o(gt_u), .diff_o(diff)
  );

  // {a, b, func, expected taken}
  localparam int NT = 10;
  localparam logic [67:0] TBL [NT] = '{
    {32'h0000_0005, 32'h0000_0005, 3'b000, 1'b1},  // R1
    {32'h0000_0005, 32'h0000_0006, 3'b001, 1'b1},  // R2
    {32'h8000_0000, 32'h7FFF_FFFF, 3'b100, 1'b1},  // R6
    {32'h7FFF_FFFF, 32'h8000_0000, 3'b100, 1'b0},  // R6
    {32'h8000_0000, 32'h7FFF_FFFF, 3'b110, 1'b0},  // R3
    {32'hFFFF_FFFF, 32'h0000_0001, 3'b101, 1'b0},  // R7
    {32'h0000_0000, 32'hFFFF_FFFF, 3'b111, 1'b0},  // R4
    {32'h0000_0007, 32'h0000_0007, 3'b111, 1'b1},  // R4
    {32'h0000_0003, 32'h0000_0003, 3'b010, 1'b0},  // R8
    {32'h0000_0003, 32'h0000_0004, 3'b011, 1'b0}   // R8
  };

  localparam int NV = 8;
  localparam logic [31:0] CORNER [NV] = '{
    32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000,
    32'h7FFF_FFFF, 32'h0000_0002, 32'hFFFF_FFFE, 32'h1234_5678
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h (a=%h b=%h fn=%b)", req, act, exp, a, b, fn);
    end
  endtask

  task automatic apply(input logic [31:0] av, input logic [31:0] bv, input logic [2:0] fv);
    a = av; b = bv; fn = fv;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic bit ref_taken(input logic [31:0] av, input logic [31:0] bv, input logic [2:0] fv);
    case (fv)
      3'b000:  return av == bv;
      3'b001:  return av != bv;
      3'b100:  return $signed(av) < $signed(bv);
      3'b101:  return $signed(av) >= $signed(bv);
      3'b110:  return av < bv;
      3'b111:  return av >= bv;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R11 reset state: inputs that would be taken
    a = 32'h5; b = 32'h5; fn = 3'b000;
    @(negedge clk); @(negedge clk);
    chk(taken == 1'b0 && zero == 1'b0, "R11 reset", {30'd0, taken, zero}, 32'd0);
    chk(diff == 32'd0 && gt_s == 1'b0 && gt_u == 1'b0 && borrow == 1'b0 && ovf == 1'b0 && sign == 1'b0,
        "R11 reset", diff, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 latency: value appears only after an edge
    a = 32'h9; b = 32'hA; fn = 3'b100;
    #1;
    chk(taken == 1'b1, "R11 latency hold", {31'd0, taken}, 32'd1);
    @(posedge clk); @(negedge clk);
    chk(taken == 1'b1 && diff == 32'hFFFF_FFFF, "R11 latency", diff, 32'hFFFF_FFFF);
    a = 32'hA; b = 32'h9; fn = 3'b100;
    #1;
    chk(taken == 1'b1, "R11 hold before edge", {31'd0, taken}, 32'd1);
    @(posedge clk); @(negedge clk);
    chk(taken == 1'b0, "R11 update", {31'd0, taken}, 32'd0);

    for (int i = 0; i < NT; i++) begin
      apply(TBL[i][67:36], TBL[i][35:4], TBL[i][3:1]);
      chk(taken == TBL[i][0], "R1-8 table", {31'd0, taken}, {31'd0, TBL[i][0]});
    end

    // R5 overflow and R9 difference on the most negative minus most positive
    apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b100);
    chk(ovf == 1'b1, "R5 ovf", {31'd0, ovf}, 32'd1);
    chk(diff == 32'h1 && sign == 1'b0 && zero == 1'b0, "R9 diff", diff, 32'h1);
    apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b101);
    chk(ovf == 1'b1 && taken == 1'b1, "R5 ovf", {30'd0, ovf, taken}, 32'd3);

    // exhaustive corner pairs, every function code
    for (int i = 0; i < NV; i++) begin
      for (int j = 0; j < NV; j++) begin
        for (int f = 0; f < 8; f++) begin
          logic [31:0] ea, eb, ed;
          bit eov;
          ea = CORNER[i]; eb = CORNER[j]; ed = ea - eb;
          eov = (ea[31] != eb[31]) && (ed[31] != ea[31]);
          apply(ea, eb, 3'(f));
          case (f)
            0: chk(taken == ref_taken(ea, eb, 3'(f)), "R1", {31'd0, taken}, {31'd0, ref_taken(ea, eb, 3'(f))});
            1: chk(taken == ref_taken(ea, eb, 3'(f)), "R2", {31'd0, taken}, {31'd0, ref_taken(ea, eb, 3'(f))});
            4: chk(taken == ref_taken(ea, eb, 3'(f)), "R6", {31'd0, taken}, {31'd0, ref_taken(ea, eb, 3'(f))});
            5: chk(taken == ref_taken(ea, eb, 3'(f)), "R7", {31'd0, taken}, {31'd0, ref_taken(ea, eb, 3'(f))});
            6: chk(taken == ref_taken(ea, eb, 3'(f)), "R3", {31'd0, taken}, {31'd0, ref_taken(ea, eb, 3'(f))});
            7: chk(taken == ref_taken(ea, eb, 3'(f)), "R4", {31'd0, taken}, {31'd0, ref_taken(ea, eb, 3'(f))});
            default: chk(taken == 1'b0, "R8", {31'd0, taken}, 32'd0);
          endcase
          if (f == 0) begin
            chk(diff == ed && zero == (ed == 0) && sign == ed[31], "R9", diff, ed);
            chk(borrow == (ea < eb), "R3 borrow", {31'd0, borrow}, {31'd0, ea < eb});
            chk(ovf == eov, "R5", {31'd0, ovf}, {31'd0, eov});
            chk(gt_s == ($signed(ea) > $signed(eb)) && gt_u == (ea > eb), "R10",
                {30'd0, gt_s, gt_u}, {30'd0, $signed(ea) > $signed(eb), ea > eb});
          end
        end
      end
    end

    // R11 reset mid-run clears outputs asynchronously
    apply(32'h4, 32'h4, 3'b000);
    rst_n = 1'b0;
    #1;
    chk(taken == 1'b0 && zero == 1'b0, "R11 async reset", {30'd0, taken, zero}, 32'd0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule